// File: doc/BRIEF.md
# Character-Synchronous Receiver with Fill and Escape Stripping

This block recovers byte framing from a serial bit stream that has no start or stop bits. The caller supplies one data bit per pulse of a sample strobe. The block then hunts, one bit at a time, for the programmed synchronisation pattern. It declares lock only after two copies of that pattern arrive back to back. From then on it cuts the stream into characters of a programmed length and hands each one to a host through a single holding register with a read handshake.

Two codes are programmed: a fill pattern and an escape pattern. Each can be removed from the delivered stream. When both are removed, the block runs a transparent rule set. Only an escape followed by a fill is dropped, and an escape that is repeated is passed through once as data. The host learns that characters were removed through two detect flags. These flags travel with the next character that is delivered. If the host falls behind, the block keeps the held character and raises an overrun flag.

Top module: `sync_char_rx`

## Requirements
- R1: After reset, `data_rdy`, `overrun`, `syn_seen`, `dle_seen` and `sync_locked` are 0, and `rx_data` is 0.
- R2: While not locked, no character is delivered and no status output changes. A fill-pattern match is looked for at every sample, once at least one character length of bits has been sampled since enable was raised.
- R3: After a fill match, the next character-length group of bits is compared with the fill pattern. On a match, `sync_locked` rises in the cycle after the last bit of that group, and the group is not delivered. On a mismatch, hunting resumes bit by bit.
- R4: Lock persists while `rx_enable` is 1. One cycle after `rx_enable` is 0, `sync_locked` is 0 and the pending detect state is cleared.
- R5: The character length is 5 + `char_len` bits, and the first received bit is bit 0. `rx_data` bits above the length are 0. Only the low length bits of `syn_code` and `dle_code` take part in comparisons.
- R6: With exactly one strip control set, a character equal to that control's code is not delivered. With `syn_strip`=0 and `dle_strip`=0, every locked character is delivered.
- R7: A stripped fill sets a pending fill flag, and a stripped escape sets a pending escape flag. Outside transparent mode, the pending flags appear on `syn_seen`/`dle_seen` with the next delivered character that equals neither code, and are then cleared. In transparent mode they appear with the next delivered character of any value.
- R8: In transparent mode (both strips set), an escape is dropped. The character after a dropped escape is dropped only if it equals the fill code. A fill not preceded by an escape is delivered, and the second of two escapes is delivered.
- R9: If a character is ready while `data_rdy` is 1 and `rd_strobe` is 0, `overrun` becomes 1. The new character is discarded, and `rx_data` and its flags are unchanged.
- R10: A `rd_strobe` pulse clears `data_rdy` and `overrun` on the next cycle. A read in the same cycle as an arrival loads the new character without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe: `rx_bit` is a valid sample |
| rx_bit | input | 1 | Serial data |
| rx_enable | input | 1 | Receiver enable; low forces hunting |
| syn_strip | input | 1 | Remove fill characters |
| dle_strip | input | 1 | Remove escape characters |
| char_len | input | 2 | Character length minus 5 |
| syn_code | input | 8 | Fill/synchronisation pattern |
| dle_code | input | 8 | Escape pattern |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_data | output | 8 | Holding register, zero-extended |
| data_rdy | output | 1 | Holding register full |
| overrun | output | 1 | A character was lost |
| syn_seen | output | 1 | Fill stripped before this character |
| dle_seen | output | 1 | Escape stripped before this character |
| sync_locked | output | 1 | Character framing established |

## Verification
Some internal faults show up only as a wrong character. A framer that locks on a single match, or one whose bit counter is off by one, delivers shifted characters on the first `data_rdy` after the second fill, which is one character time later. A lost escape-follow state or a lost pending flag shows on the next delivered character, either as a wrong value or as wrong `syn_seen`/`dle_seen`. A holding stage that overwrites on overrun changes `rx_data` within the same character time.

// File: rtl/syncrx_pkg.sv
package syncrx_pkg;

    localparam int CHAR_W  = 8;
    localparam int SEL_W   = 2;
    localparam int MIN_LEN = 5;
    localparam int LEN_W   = $clog2(CHAR_W + 1);

    typedef enum logic [1:0] {
        FR_HUNT   = 2'd0,
        FR_VERIFY = 2'd1,
        FR_LOCKED = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              syn_seen;
        logic              dle_seen;
    } rx_item_t;

    function automatic logic [LEN_W-1:0] char_bits(input logic [SEL_W-1:0] sel);
        return LEN_W'(MIN_LEN) + LEN_W'(sel);
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (LEN_W'(i) < len);
        end
        return m;
    endfunction

endpackage

// File: rtl/syncrx_shift.sv
module syncrx_shift
    import syncrx_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          bit_en,
    input  logic          rx_bit,
    input  logic [LW-1:0] len,
    output logic [W-1:0]  window,
    output logic          fill_ok
);

    logic [W-1:0]  sh_q;
    logic [W-1:0]  sh_next;
    logic [LW-1:0] fill_q;
    logic [LW-1:0] sh_amt;

    // newest bit enters at the top; oldest sits at the bottom
    assign sh_next = {rx_bit, sh_q[W-1:1]};
    assign sh_amt  = LW'(W) - len;
    assign window  = sh_next >> sh_amt;
    assign fill_ok = (fill_q >= (len - LW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            fill_q <= '0;
        end else begin
            if (bit_en) begin
                sh_q <= sh_next;
            end
            if (clr) begin
                fill_q <= '0;
            end else if (bit_en && (fill_q != LW'(W))) begin
                fill_q <= fill_q + LW'(1);
            end
        end
    end

endmodule

// File: rtl/syncrx_framer.sv
module syncrx_framer
    import syncrx_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          bit_en,
    input  logic [W-1:0]  window,
    input  logic          fill_ok,
    input  logic [W-1:0]  syn_m,
    input  logic [LW-1:0] len,
    output logic          locked,
    output logic          char_strobe
);

    fr_state_e     state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;
    logic          done;
    logic          is_syn;

    assign done   = (cnt_q == (len - LW'(1)));
    assign is_syn = (window == syn_m);
    assign locked = (state_q == FR_LOCKED);

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        char_strobe = 1'b0;
        if (!enable) begin
            state_d = FR_HUNT;
            cnt_d   = '0;
        end else if (bit_en) begin
            unique case (state_q)
                FR_HUNT: begin
                    if (fill_ok && is_syn) begin
                        state_d = FR_VERIFY;
                        cnt_d   = '0;
                    end
                end
                FR_VERIFY: begin
                    if (done) begin
                        state_d = is_syn ? FR_LOCKED : FR_HUNT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + LW'(1);
                    end
                end
                FR_LOCKED: begin
                    if (done) begin
                        char_strobe = 1'b1;
                        cnt_d       = '0;
                    end else begin
                        cnt_d = cnt_q + LW'(1);
                    end
                end
                default: begin
                    state_d = FR_HUNT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/syncrx_filter.sv
module syncrx_filter
    import syncrx_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         char_strobe,
    input  logic [W-1:0] char_val,
    input  logic [W-1:0] syn_m,
    input  logic [W-1:0] dle_m,
    input  logic         syn_strip,
    input  logic         dle_strip,
    output logic         deliver,
    output rx_item_t     item
);

    logic after_dle_q;
    logic pend_syn_q;
    logic pend_dle_q;
    logic is_syn, is_dle, xpar;
    logic drop, drop_syn, drop_dle, attach;

    assign is_syn = (char_val == syn_m);
    assign is_dle = (char_val == dle_m);
    assign xpar   = syn_strip & dle_strip;

    always_comb begin
        if (xpar) begin
            drop_syn = after_dle_q & is_syn;
            drop_dle = ~after_dle_q & is_dle;
            attach   = 1'b1;
        end else begin
            drop_syn = syn_strip & is_syn;
            drop_dle = dle_strip & is_dle;
            attach   = ~(is_syn | is_dle);
        end
        drop          = drop_syn | drop_dle;
        deliver       = char_strobe & ~drop;
        item.data     = char_val;
        item.syn_seen = pend_syn_q & attach;
        item.dle_seen = pend_dle_q & attach;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            after_dle_q <= 1'b0;
            pend_syn_q  <= 1'b0;
            pend_dle_q  <= 1'b0;
        end else if (char_strobe) begin
            after_dle_q <= drop_dle & xpar;
            if (drop_syn) begin
                pend_syn_q <= 1'b1;
            end
            if (drop_dle) begin
                pend_dle_q <= 1'b1;
            end
            if (!drop && attach) begin
                pend_syn_q <= 1'b0;
                pend_dle_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/syncrx_hold.sv
module syncrx_hold
    import syncrx_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         deliver,
    input  rx_item_t     item,
    input  logic         rd_strobe,
    output logic [W-1:0] rx_data,
    output logic         data_rdy,
    output logic         overrun,
    output logic         syn_seen,
    output logic         dle_seen
);

    rx_item_t held_q;
    logic     full_q;
    logic     ovr_q;
    logic     busy;

    assign busy = full_q & ~rd_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (rd_strobe) begin
                full_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (deliver) begin
                if (busy) begin
                    ovr_q <= 1'b1;
                end else begin
                    held_q <= item;
                    full_q <= 1'b1;
                end
            end
        end
    end

    assign rx_data  = held_q.data;
    assign syn_seen = held_q.syn_seen;
    assign dle_seen = held_q.dle_seen;
    assign data_rdy = full_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
    import syncrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              rx_enable,
    input  logic              syn_strip,
    input  logic              dle_strip,
    input  logic [SEL_W-1:0]  char_len,
    input  logic [CHAR_W-1:0] syn_code,
    input  logic [CHAR_W-1:0] dle_code,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              data_rdy,
    output logic              overrun,
    output logic              syn_seen,
    output logic              dle_seen,
    output logic              sync_locked
);

    logic [LEN_W-1:0]  len;
    logic [CHAR_W-1:0] mask;
    logic [CHAR_W-1:0] syn_m, dle_m;
    logic [CHAR_W-1:0] window;
    logic              fill_ok;
    logic              char_strobe;
    logic              deliver;
    rx_item_t          item;

    assign len   = char_bits(char_len);
    assign mask  = len_mask(len);
    assign syn_m = syn_code & mask;
    assign dle_m = dle_code & mask;

    syncrx_shift #(.W(CHAR_W), .LW(LEN_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clr     (~rx_enable),
        .bit_en  (bit_en),
        .rx_bit  (rx_bit),
        .len     (len),
        .window  (window),
        .fill_ok (fill_ok)
    );

    syncrx_framer #(.W(CHAR_W), .LW(LEN_W)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .enable      (rx_enable),
        .bit_en      (bit_en),
        .window      (window),
        .fill_ok     (fill_ok),
        .syn_m       (syn_m),
        .len         (len),
        .locked      (sync_locked),
        .char_strobe (char_strobe)
    );

    syncrx_filter #(.W(CHAR_W)) u_filter (
        .clk         (clk),
        .rst         (rst),
        .enable      (rx_enable),
        .char_strobe (char_strobe),
        .char_val    (window),
        .syn_m       (syn_m),
        .dle_m       (dle_m),
        .syn_strip   (syn_strip),
        .dle_strip   (dle_strip),
        .deliver     (deliver),
        .item        (item)
    );

    syncrx_hold #(.W(CHAR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .deliver   (deliver),
        .item      (item),
        .rd_strobe (rd_strobe),
        .rx_data   (rx_data),
        .data_rdy  (data_rdy),
        .overrun   (overrun),
        .syn_seen  (syn_seen),
        .dle_seen  (dle_seen)
    );

endmodule

// File: rtl/syncrx_chk.sv
module syncrx_chk
    import syncrx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              rx_enable,
    input logic              rd_strobe,
    input logic [CHAR_W-1:0] rx_data,
    input logic              data_rdy,
    input logic              overrun,
    input logic              sync_locked
);

    // R2
    new_data_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_rdy) |-> $past(sync_locked));

    // R3
    lock_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_locked) |-> $past(bit_en));

    // R4
    disable_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !sync_locked);

    // R9
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $stable(rx_data));

    // R9
    held_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rdy && !rd_strobe) |=> $stable(rx_data));

    // R10
    read_clears_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !overrun);

endmodule

bind sync_char_rx syncrx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_en      (bit_en),
    .rx_enable   (rx_enable),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .data_rdy    (data_rdy),
    .overrun     (overrun),
    .sync_locked (sync_locked)
);

// File: tb/sim_sync_char_rx.sv
`timescale 1ns/1ps
module sim_sync_char_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       rx_enable = 1'b0;
    logic       syn_strip = 1'b0;
    logic       dle_strip = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic [7:0] syn_code = 8'h16;
    logic [7:0] dle_code = 8'h10;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       data_rdy, overrun, syn_seen, dle_seen, sync_locked;

    int checks = 0;
    int errors = 0;
    logic auto_read = 1'b1;

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       e;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    sync_char_rx u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .rx_enable(rx_enable), .syn_strip(syn_strip), .dle_strip(dle_strip),
        .char_len(char_len), .syn_code(syn_code), .dle_code(dle_code),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .data_rdy(data_rdy),
        .overrun(overrun), .syn_seen(syn_seen), .dle_seen(dle_seen),
        .sync_locked(sync_locked)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_char(input logic [7:0] d, input logic s, input logic e, input string tag);
        exp_t it;
        it.d = d; it.s = s; it.e = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    // monitor: pops expected items as the design presents them
    initial begin
        forever begin
            @(negedge clk);
            if (rd_strobe) begin
                rd_strobe = 1'b0;
                check("R10 data_rdy after read", {7'd0, data_rdy}, 8'd0);
            end else if (data_rdy && auto_read && !rst) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2 unexpected char actual=%h expected=none", rx_data);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check({it.tag, " data"}, rx_data, it.d);
                    check({it.tag, " syn_seen"}, {7'd0, syn_seen}, {7'd0, it.s});
                    check({it.tag, " dle_seen"}, {7'd0, dle_seen}, {7'd0, it.e});
                end
                rd_strobe = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 data_rdy", {7'd0, data_rdy}, 8'd0);
        check("R1 overrun", {7'd0, overrun}, 8'd0);
        check("R1 sync_locked", {7'd0, sync_locked}, 8'd0);
        check("R1 rx_data", rx_data, 8'h00);

        // R2/R3: hunt, failed verify, then proper lock
        rx_enable = 1'b1;
        repeat (4) send_bit(1'b1);
        send_char(8'h16, 8);
        send_char(8'h55, 8);
        check("R3 no lock after mismatch", {7'd0, sync_locked}, 8'd0);
        check("R2 nothing delivered while hunting", {7'd0, data_rdy}, 8'd0);
        send_char(8'h16, 8);
        send_char(8'h16, 8);
        check("R3 locked after two fills", {7'd0, sync_locked}, 8'd1);
        expect_char(8'h41, 1'b0, 1'b0, "R6 plain");
        send_char(8'h41, 8);
        expect_char(8'h16, 1'b0, 1'b0, "R6 fill kept without strip");
        send_char(8'h16, 8);

        // R6/R7 fill strip only
        syn_strip = 1'b1;
        send_char(8'h16, 8);
        expect_char(8'h42, 1'b1, 1'b0, "R7 fill flag");
        send_char(8'h42, 8);
        expect_char(8'h43, 1'b0, 1'b0, "R7 flag cleared");
        send_char(8'h43, 8);

        // R6/R7 escape strip only
        syn_strip = 1'b0;
        dle_strip = 1'b1;
        send_char(8'h10, 8);
        expect_char(8'h16, 1'b0, 1'b0, "R7 fill defers flag");
        send_char(8'h16, 8);
        expect_char(8'h44, 1'b0, 1'b1, "R7 escape flag");
        send_char(8'h44, 8);

        // R8 transparent
        syn_strip = 1'b1;
        send_char(8'h10, 8);
        send_char(8'h16, 8);
        expect_char(8'h45, 1'b1, 1'b1, "R8 pair stripped");
        send_char(8'h45, 8);
        send_char(8'h10, 8);
        expect_char(8'h10, 1'b0, 1'b1, "R8 doubled escape");
        send_char(8'h10, 8);
        expect_char(8'h16, 1'b0, 1'b0, "R8 lone fill kept");
        send_char(8'h16, 8);
        syn_strip = 1'b0;
        dle_strip = 1'b0;

        // R9 overrun
        auto_read = 1'b0;
        expect_char(8'h61, 1'b0, 1'b0, "R9 old char kept");
        send_char(8'h61, 8);
        send_char(8'h62, 8);
        check("R9 overrun set", {7'd0, overrun}, 8'd1);
        check("R9 held data", rx_data, 8'h61);
        auto_read = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 overrun cleared by read", {7'd0, overrun}, 8'd0);

        // R4 disable, R5 short characters
        rx_enable = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 unlocked when disabled", {7'd0, sync_locked}, 8'd0);
        char_len = 2'd0;
        rx_enable = 1'b1;
        repeat (3) send_bit(1'b1);
        send_char(8'h16, 5);
        check("R3 not locked after single fill", {7'd0, sync_locked}, 8'd0);
        send_char(8'h16, 5);
        check("R5 locked with 5-bit length", {7'd0, sync_locked}, 8'd1);
        expect_char(8'h1F, 1'b0, 1'b0, "R5 five-bit all ones");
        send_char(8'hFF, 5);
        expect_char(8'h0A, 1'b0, 1'b0, "R5 five-bit value");
        send_char(8'h0A, 5);

        repeat (10) @(negedge clk);
        check("R2 all expected delivered", 8'(exp_q.size()), 8'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule